// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Write Unlock

This block sits on a register bus and controls nonvolatile memory operations. Software sets a 24-bit target address, split over a low and a high register. It then writes two fixed key values to a key register. In the cycle right after the second key write, a write to the control register may set the start bit. The block then checks the operation code, the enable bit and the address alignment. If all of them are legal, it runs a timed operation: a configuration word write, a double-word program, a row program or a page erase.

While an operation runs, the block holds the CPU stall output high and exposes the frozen operation and address to the array side. It masks incoming interrupt requests and keeps them pending. It also defers any soft reset request. When the timer expires, the start bit clears, a one-cycle completion pulse is raised, and held interrupts and resets are released. A rejected start sets a sticky error flag and does not touch the array.

Top module: `nvm_ctrl`

## Requirements
- R1: Unlock is a write of 0x0055 to the key register (bus address 3) followed by a write of 0x00AA to it. Idle cycles between the two writes are allowed. Any other bus write between them, a wrong key value, or the two values in reverse order cancels the unlock.
- R2: A control write (bus address 0) with bit 15 set starts an operation only on the clock edge right after the 0x00AA write. At any later edge the start bit is ignored and neither the stall output nor the error flag (bit 13) changes.
- R3: A started operation keeps `stall_o`, `arr_go_o` and control bit 15 high for a fixed number of cycles: 3 for configuration write, 5 for double-word, 9 for row and 14 for page erase. Control bit 15 then clears by itself.
- R4: `done_irq_o` is high for exactly one cycle, the first cycle after the start bit has cleared.
- R5: Control bits [3:0] select the operation: 0 configuration write, 1 double-word program, 2 row program, 3 page erase. Bit 14 must be 1. Any other opcode, or bit 14 at 0, rejects the start.
- R6: Alignment rules depend on the operation. A double-word program needs address bits [1:0] at zero. A row program (8 words) needs bits [3:0] at zero. A page erase (32 words) needs bits [5:0] at zero. A misaligned start is rejected.
- R7: A configuration write (control value 0xC000 with the start bit) also needs address bit 23 set and address bit 0 clear.
- R8: Bus address 1 holds address bits [15:0]. Bus address 2 holds bits [23:16] in its low byte and reads the upper byte as zero. Both registers read back. Writes to them are ignored during an operation, and `arr_addr_o` and `arr_op_o` stay constant for the whole operation.
- R9: While an operation runs, `irq_o` is low. A request seen on `irq_i` during that time appears on `irq_o` in the first cycle after the operation ends.
- R10: A pulse on `soft_rst_req_i` gives a one-cycle `soft_rst_o`. When the block is idle this happens in the next cycle. During an operation it is delayed until the first cycle after the operation.
- R11: Driving `rst_ni` low aborts a running operation at once and clears every register to zero.
- R12: A rejected start sets control bit 13. The bit stays set until a control write with bit 13 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts any operation |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 key |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`; the key register reads zero |
| irq_i | input | 1 | Incoming interrupt request |
| irq_o | output | 1 | Interrupt request passed to the CPU, held back while busy |
| soft_rst_req_i | input | 1 | Non-power reset request |
| soft_rst_o | output | 1 | Soft reset released once no operation runs |
| stall_o | output | 1 | CPU stall while an operation runs |
| done_irq_o | output | 1 | One-cycle completion pulse |
| arr_go_o | output | 1 | Array operation active |
| arr_op_o | output | 2 | Array operation kind |
| arr_addr_o | output | 24 | Array target address |

## Verification
A wrong unlock state shows up on the edge after the start write. Either `stall_o` rises when it should not, or a legal start is dropped. Both are visible one cycle later in control bits 15 and 13. A miscounted timer or a wrong duration decode shows up as a stall length that differs from the table for that opcode. A lost completion pulse is seen in the cycle after stall falls. The bench sweeps the low six address bits for every opcode and the whole opcode space, so a faulty alignment mask or opcode decode flips the outcome of at least one start within a few cycles.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    K_CFG   = 2'd0,
    K_DWORD = 2'd1,
    K_ROW   = 2'd2,
    K_PAGE  = 2'd3
  } nvm_kind_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADRL = 2'd1,
    REG_ADRH = 2'd2,
    REG_KEY  = 2'd3
  } nvm_reg_e;

  localparam int CTRL_START = 15;
  localparam int CTRL_EN    = 14;
  localparam int CTRL_ERR   = 13;
  localparam int OP_W       = 4;
  localparam int ADDR_W     = 24;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        busy_i,
  input  logic        wr_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [15:0] wdata_i,
  output logic        open_o
);
  typedef enum logic [1:0] {L_IDLE, L_HALF, L_OPEN} lock_e;
  lock_e state_q, state_d;

  logic key_wr;
  assign key_wr = wr_i && (wr_addr_i == REG_KEY);

  always_comb begin
    state_d = L_IDLE;
    unique case (state_q)
      L_IDLE: state_d = (key_wr && wdata_i == KEY_FIRST) ? L_HALF : L_IDLE;
      L_HALF: begin
        if (!wr_i)                            state_d = L_HALF;
        else if (key_wr && wdata_i == KEY_SECOND) state_d = L_OPEN;
        else                                  state_d = L_IDLE;
      end
      default: state_d = L_IDLE;
    endcase
    if (busy_i) state_d = L_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= L_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == L_OPEN);

  // R2: the start window never lasts longer than one cycle
  p_window_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> !open_o);

  // R1: the window only opens after a second key write
  p_window_after_key_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr));
endmodule

// File: rtl/nvm_check.sv
module nvm_check
  import nvm_pkg::*;
#(
  parameter int ROW_WORDS  = 8,
  parameter int PAGE_WORDS = 32,
  parameter int T_CFG      = 3,
  parameter int T_DWORD    = 5,
  parameter int T_ROW      = 9,
  parameter int T_PAGE     = 14,
  parameter int DUR_W      = 4
) (
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic [DUR_W-1:0]  dur_o
);
  // two address units per instruction word
  localparam logic [ADDR_W-1:0] DW_MASK   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ROW_MASK  = ADDR_W'(ROW_WORDS * 2 - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_WORDS * 2 - 1);

  logic aligned;

  always_comb begin
    aligned = 1'b0;
    dur_o   = '0;
    unique case (op_i)
      4'd0: begin aligned = addr_i[ADDR_W-1] && !addr_i[0];      dur_o = DUR_W'(T_CFG);   end
      4'd1: begin aligned = (addr_i & DW_MASK) == '0;            dur_o = DUR_W'(T_DWORD); end
      4'd2: begin aligned = (addr_i & ROW_MASK) == '0;           dur_o = DUR_W'(T_ROW);   end
      4'd3: begin aligned = (addr_i & PAGE_MASK) == '0;          dur_o = DUR_W'(T_PAGE);  end
      default: aligned = 1'b0;
    endcase
    ok_o = en_i && aligned;
  end
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
  parameter int DUR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [DUR_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= dur_i;
      end else if (busy_q) begin
        if (cnt_q <= DUR_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R4: completion pulse follows the end of busy and lasts one cycle
  p_done_after_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3: a running count never restarts
  p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ROW_WORDS  = 8,
  parameter int PAGE_WORDS = 32,
  parameter int T_CFG      = 3,
  parameter int T_DWORD    = 5,
  parameter int T_ROW      = 9,
  parameter int T_PAGE     = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        irq_i,
  output logic        irq_o,
  input  logic        soft_rst_req_i,
  output logic        soft_rst_o,
  output logic        stall_o,
  output logic        done_irq_o,
  output logic        arr_go_o,
  output logic [1:0]  arr_op_o,
  output logic [23:0] arr_addr_o
);
  localparam int T_MAX = max4(T_CFG, T_DWORD, T_ROW, T_PAGE);
  localparam int DUR_W = $clog2(T_MAX + 1);
  localparam int HI_W  = ADDR_W - 16;

  logic              busy, done, win_open, chk_ok;
  logic [DUR_W-1:0]  dur;
  logic              en_q, err_q;
  logic [OP_W-1:0]   op_q;
  logic [15:0]       adr_lo_q;
  logic [HI_W-1:0]   adr_hi_q;
  logic              irq_pend_q, soft_pend_q;
  logic              wr_ctrl, start_try, start_go;

  nvm_unlock i_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .wr_i      (bus_we_i),
    .wr_addr_i (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .open_o    (win_open)
  );

  nvm_check #(
    .ROW_WORDS (ROW_WORDS), .PAGE_WORDS (PAGE_WORDS),
    .T_CFG (T_CFG), .T_DWORD (T_DWORD), .T_ROW (T_ROW), .T_PAGE (T_PAGE),
    .DUR_W (DUR_W)
  ) i_check (
    .en_i   (bus_wdata_i[CTRL_EN]),
    .op_i   (bus_wdata_i[OP_W-1:0]),
    .addr_i ({adr_hi_q, adr_lo_q}),
    .ok_o   (chk_ok),
    .dur_o  (dur)
  );

  nvm_timer #(.DUR_W (DUR_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_go),
    .dur_i   (dur),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign wr_ctrl   = bus_we_i && (bus_addr_i == REG_CTRL) && !busy;
  assign start_try = wr_ctrl && bus_wdata_i[CTRL_START] && win_open;
  assign start_go  = start_try && chk_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      op_q     <= '0;
      adr_lo_q <= '0;
      adr_hi_q <= '0;
    end else if (bus_we_i && !busy) begin
      unique case (bus_addr_i)
        REG_CTRL: begin
          en_q  <= bus_wdata_i[CTRL_EN];
          op_q  <= bus_wdata_i[OP_W-1:0];
          err_q <= (start_try && !chk_ok) ? 1'b1 : (err_q && bus_wdata_i[CTRL_ERR]);
        end
        REG_ADRL: adr_lo_q <= bus_wdata_i;
        REG_ADRH: adr_hi_q <= bus_wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  // held interrupt requests and deferred soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pend_q  <= 1'b0;
      soft_pend_q <= 1'b0;
    end else begin
      irq_pend_q  <= busy && (irq_pend_q || irq_i);
      soft_pend_q <= (soft_pend_q || soft_rst_req_i) && !soft_rst_o;
    end
  end

  assign irq_o      = !busy && (irq_pend_q || irq_i);
  assign soft_rst_o = soft_pend_q && !busy;
  assign stall_o    = busy;
  assign done_irq_o = done;
  assign arr_go_o   = busy;
  assign arr_op_o   = op_q[1:0];
  assign arr_addr_o = {adr_hi_q, adr_lo_q};

  always_comb begin
    unique case (bus_addr_i)
      REG_CTRL: bus_rdata_o = {busy, en_q, err_q, {(13-OP_W){1'b0}}, op_q};
      REG_ADRL: bus_rdata_o = adr_lo_q;
      REG_ADRH: bus_rdata_o = {{(16-HI_W){1'b0}}, adr_hi_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  p_start_after_unlock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(win_open));
  p_bad_start_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_try && !chk_ok) |=> (err_q && !stall_o));
  p_cfg_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && arr_op_o == K_CFG) |-> (arr_addr_o[ADDR_W-1] && !arr_addr_o[0]));
  p_addr_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |-> ($stable(arr_addr_o) && $stable(arr_op_o)));
  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !irq_o);
  p_soft_defer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !stall_o);
  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(bus_we_i && bus_addr_i == REG_CTRL)) |=> err_q);
endmodule

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_in = 1'b0, irq_out;
  logic        srst_req = 1'b0, srst;
  logic        stall, done, go;
  logic [1:0]  aop;
  logic [23:0] aaddr;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  nvm_ctrl i_nvm_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .irq_i (irq_in), .irq_o (irq_out),
    .soft_rst_req_i (srst_req), .soft_rst_o (srst),
    .stall_o (stall), .done_irq_o (done),
    .arr_go_o (go), .arr_op_o (aop), .arr_addr_o (aaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic bit exp_ok(input bit en, input logic [3:0] op, input logic [23:0] a);
    if (!en) return 1'b0;
    case (op)
      4'd0: return a[23] && !a[0];
      4'd1: return a[1:0] == 2'b0;
      4'd2: return a[3:0] == 4'b0;
      4'd3: return a[5:0] == 6'b0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_dur(input logic [3:0] op);
    case (op)
      4'd0: return 3;
      4'd1: return 5;
      4'd2: return 9;
      default: return 14;
    endcase
  endfunction

  // evaluates the outcome of a start write that just completed
  task automatic outcome(input bit ok, input logic [3:0] op, input logic [23:0] a, input string req);
    logic [15:0] d;
    int n;
    bit mism;
    if (ok) begin
      n = 0; mism = 0;
      while (stall === 1'b1 && n < 64) begin
        if (aaddr !== a || aop !== op[1:0] || go !== 1'b1) mism = 1;
        n++;
        @(negedge clk);
      end
      chk(n == exp_dur(op), {req, " R3 busy length"}, n, exp_dur(op));
      chk(done === 1'b1, {req, " R4 done pulse"}, done, 1);
      rd(0, d);
      chk(d[15] === 1'b0, {req, " R3 start bit self-clear"}, d[15], 0);
      chk(!mism, {req, " R8 array outputs frozen"}, aaddr, a);
      @(negedge clk);
      chk(done === 1'b0, {req, " R4 done one cycle"}, done, 0);
    end else begin
      chk(stall === 1'b0, {req, " rejected start stalls"}, stall, 0);
      rd(0, d);
      chk(d[13] === 1'b1, {req, " R12 error flag set"}, d[13], 1);
      @(negedge clk);
    end
  endtask

  task automatic try_start(input bit en, input logic [3:0] op, input logic [15:0] lo,
                           input logic [7:0] hi, input string req);
    wr(0, 16'h0000);
    wr(1, lo);
    wr(2, {8'h00, hi});
    wr(3, 16'h0055);
    wr(3, 16'h00AA);
    wr(0, {1'b1, en, 10'b0, op});
    outcome(exp_ok(en, op, {hi, lo}), op, {hi, lo}, req);
  endtask

  task automatic expect_ignored(input string req);
    logic [15:0] d;
    chk(stall === 1'b0, {req, " start ignored"}, stall, 0);
    rd(0, d);
    chk(d[15:13] == 3'b010, {req, " no start no error"}, d[15:13], 3'b010);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(0, d); chk(d == 16'h0, "R11 reset ctrl", d, 0);
    rd(1, d); chk(d == 16'h0, "R11 reset adr low", d, 0);
    chk(stall === 1'b0 && done === 1'b0 && srst === 1'b0 && irq_out === 1'b0,
        "R11 reset outputs", {stall, done, srst, irq_out}, 0);

    // R8 address register readback
    @(negedge clk);
    wr(1, 16'h1234); wr(2, 16'hFFAB);
    rd(1, d); chk(d == 16'h1234, "R8 adr low readback", d, 16'h1234);
    rd(2, d); chk(d == 16'h00AB, "R8 adr high readback", d, 16'h00AB);
    rd(3, d); chk(d == 16'h0, "R8 key reads zero", d, 0);
    @(negedge clk);

    // R5 R6 R7: alignment sweep for every legal opcode
    for (int op = 0; op < 4; op++) begin
      for (int lo = 0; lo < 64; lo++) begin
        try_start(1'b1, 4'(op), 16'hA400 | 16'(lo), (op == 0) ? 8'h80 : 8'h12, "R6 R7 sweep");
      end
    end
    // R7 configuration write needs bit 23
    try_start(1'b1, 4'd0, 16'h0000, 8'h12, "R7 cfg without bit23");
    try_start(1'b1, 4'd0, 16'h0004, 8'hC0, "R7 cfg with bit23");
    // R5 unimplemented opcodes and enable bit
    for (int op = 4; op < 16; op++) try_start(1'b1, 4'(op), 16'h0000, 8'h00, "R5 bad opcode");
    try_start(1'b0, 4'd1, 16'h0000, 8'h00, "R5 enable clear");

    // R12 error flag stickiness
    try_start(1'b1, 4'd9, 16'h0000, 8'h00, "R12 set");
    wr(0, 16'h2000);
    rd(0, d); chk(d[13] === 1'b1, "R12 kept with bit13 written 1", d[13], 1);
    @(negedge clk);
    wr(0, 16'h0000);
    rd(0, d); chk(d[13] === 1'b0, "R12 cleared", d[13], 0);
    @(negedge clk);

    // R1 unlock negatives
    wr(1, 16'h0000); wr(2, 16'h0000);
    wr(3, 16'h0055); wr(3, 16'h00AB); wr(3, 16'h00AA); wr(0, 16'hC001);
    expect_ignored("R1 wrong second key");
    wr(3, 16'h0055); wr(1, 16'h0000); wr(3, 16'h00AA); wr(0, 16'hC001);
    expect_ignored("R1 access between keys");
    wr(3, 16'h00AA); wr(3, 16'h0055); wr(0, 16'hC001);
    expect_ignored("R1 reversed keys");
    wr(3, 16'h0056); wr(3, 16'h00AA); wr(0, 16'hC001);
    expect_ignored("R1 wrong first key");
    // R1 idle cycles between keys allowed
    wr(3, 16'h0055); repeat (3) @(negedge clk); wr(3, 16'h00AA); wr(0, 16'hC001);
    outcome(1'b1, 4'd1, 24'h0, "R1 gap between keys");

    // R2 window is one cycle
    wr(3, 16'h0055); wr(3, 16'h00AA); @(negedge clk); wr(0, 16'hC001);
    expect_ignored("R2 late start");
    wr(3, 16'h0055); wr(3, 16'h00AA); wr(2, 16'h0000); wr(0, 16'hC001);
    expect_ignored("R2 write inside window");
    wr(0, 16'hC001);
    expect_ignored("R2 start without unlock");

    // R8 address writes ignored while busy, R9 held irq, R10 deferred soft reset
    wr(1, 16'h0010); wr(2, 16'h0003);
    wr(3, 16'h0055); wr(3, 16'h00AA); wr(0, 16'hC002);
    chk(stall === 1'b1, "R3 row started", stall, 1);
    wr(1, 16'hFFFF);
    irq_in = 1'b1; srst_req = 1'b1;
    @(negedge clk);
    irq_in = 1'b0; srst_req = 1'b0;
    chk(irq_out === 1'b0, "R9 irq held while busy", irq_out, 0);
    chk(srst === 1'b0, "R10 soft reset deferred", srst, 0);
    chk(aaddr == 24'h030010, "R8 array address frozen", aaddr, 24'h030010);
    while (stall === 1'b1) @(negedge clk);
    chk(irq_out === 1'b1, "R9 irq released", irq_out, 1);
    chk(srst === 1'b1, "R10 soft reset released", srst, 1);
    rd(1, d); chk(d == 16'h0010, "R8 busy write ignored", d, 16'h0010);
    @(negedge clk);
    chk(irq_out === 1'b0 && srst === 1'b0, "R9 R10 one cycle", {irq_out, srst}, 0);

    // R10 idle soft reset
    srst_req = 1'b1;
    @(negedge clk);
    srst_req = 1'b0;
    chk(srst === 1'b1, "R10 idle soft reset next cycle", srst, 1);
    @(negedge clk);
    chk(srst === 1'b0, "R10 idle soft reset one cycle", srst, 0);

    // R11 abort in flight
    wr(1, 16'h0000); wr(2, 16'h0000);
    wr(3, 16'h0055); wr(3, 16'h00AA); wr(0, 16'hC003);
    repeat (4) @(negedge clk);
    chk(stall === 1'b1, "R11 erase running", stall, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk(stall === 1'b0 && go === 1'b0, "R11 abort immediate", {stall, go}, 0);
    rd(0, d); chk(d == 16'h0, "R11 ctrl cleared", d, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && stall === 1'b0, "R11 no completion after abort", {done, stall}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule